// File: doc/BRIEF.md
# Outbound Window Address Translator

This block maps addresses from a local bus into a remote bus's address space. It holds up to six windows. Each window is set by a base address, a high address and a translation vector. A window's size comes from its base/high pair, which must describe a naturally aligned power-of-two span. Each window is declared either 32-bit or 64-bit.

A lookup compares the presented address against every enabled window. On a hit, the block keeps the address bits that lie inside the window. It fills the bits above them from that window's translation vector and reports the index of the window that matched. A bus master front end would place the block between its local request decode and the remote request builder. The translation vectors can be rewritten through a small write port when dynamic translation is enabled, so software can move a window's remote target while the system runs.

The result is registered: a lookup presented in one cycle gives its translated address, hit flag and window index after the next clock edge.

Top module: `obwin_xlat`

## Requirements
- R1: A lookup presented with `lk_valid` high before a rising clock edge drives `out_valid` high after that edge, together with its result. A cycle with `lk_valid` low gives `out_valid` low after the edge.
- R2: A window's span is set by a mask equal to base XOR high. An address hits the window when its bits outside that mask equal the base's bits outside that mask, so both the base and the high address hit, and the addresses one below the base and one above the high address miss.
- R3: On a hit, the output address takes its bits inside the window mask from the input address and its bits above the mask from the translation vector. Vector bits inside the mask have no effect.
- R4: A 32-bit window (its bit in `WIN_IS64` is 0) hits only when input bits [63:32] are zero. Its output bits [63:32] are always zero, whatever the upper half of its vector holds.
- R5: A 64-bit window (its bit in `WIN_IS64` is 1) compares and translates all 64 address bits.
- R6: A valid lookup that hits no window gives `out_hit` = 0, `out_addr` = 0 and `out_win` = 0.
- R7: When several windows hit, the lowest-numbered window supplies the result and the index.
- R8: Only windows with an index below `NUM_WIN` take part in matching. Higher windows never hit.
- R9: With `DYN_XLAT` = 1, a write (`wr_en`, `wr_idx`, `wr_data`) replaces that window's vector. A lookup in the cycle after the write uses the new vector. A lookup in the same cycle as the write uses the old vector.
- R10: Writes with `wr_idx` >= `NUM_WIN` change nothing. With `DYN_XLAT` = 0, every write is ignored and the vectors keep their parameter values.
- R11: A reset clears `out_valid`, `out_hit`, `out_win` and `out_addr` to zero and restores every translation vector to its parameter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | 64 | Local address to translate |
| wr_en | input | 1 | Translation vector write strobe |
| wr_idx | input | 3 | Window index of the vector write |
| wr_data | input | 64 | New translation vector |
| out_valid | output | 1 | Registered result is valid |
| out_hit | output | 1 | The lookup matched a window |
| out_win | output | 3 | Index of the matching window |
| out_addr | output | 64 | Translated remote address |

## Verification
The bench probes both edges of each window: the base and the high address must hit, and the addresses just outside must miss. A design that derives the span with an off-by-one or a subtraction would leak a neighbouring address into the window or drop its last address. It sends addresses with non-zero upper halves to the 32-bit windows and writes a vector whose upper half is set, which catches a design that ignores the window width. It uses overlapping windows to check that the lowest index wins; a reversed priority encoder would report the wider window. It then places a write and a lookup in the same cycle and in adjacent cycles, sends writes to out-of-range indices and to a fixed-vector instance, and resets mid-run. These catch a design that forwards writes early, lets stray writes through, or keeps stale vectors after reset.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int MAX_WIN = 6;
  localparam int AW      = 64;
  localparam int IDX_W   = 3;

  // Span mask of a window; a narrow window never covers the upper half.
  function automatic logic [AW-1:0] win_mask(input logic [AW-1:0] base,
                                             input logic [AW-1:0] high,
                                             input logic           is64);
    logic [AW-1:0] m;
    m = base ^ high;
    if (!is64) m[AW-1:AW/2] = '0;
    return m;
  endfunction
endpackage

// File: rtl/obwin_vec_regs.sv
module obwin_vec_regs import obwin_pkg::*; #(
  parameter int NUM_WIN  = 6,
  parameter bit DYN_XLAT = 1'b1,
  parameter logic [MAX_WIN*AW-1:0] VEC_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [AW-1:0]         wr_data,
  output logic [MAX_WIN*AW-1:0] vec_q
);
  logic wr_ok;
  assign wr_ok = DYN_XLAT && wr_en && (int'(wr_idx) < NUM_WIN);

  for (genvar g = 0; g < MAX_WIN; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (rst)
        vec_q[g*AW +: AW] <= VEC_INIT[g*AW +: AW];
      else if (wr_ok && wr_idx == IDX_W'(g))
        vec_q[g*AW +: AW] <= wr_data;
    end
  end
endmodule

// File: rtl/obwin_match.sv
module obwin_match import obwin_pkg::*; #(
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] HIGH = '0,
  parameter bit            IS64 = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] vec,
  output logic          hit,
  output logic [AW-1:0] xaddr
);
  localparam logic [AW-1:0] MASK = win_mask(BASE, HIGH, IS64);
  localparam logic [AW-1:0] KEEP = IS64 ? {AW{1'b1}} : {{(AW/2){1'b0}}, {(AW/2){1'b1}}};

  logic upper_ok;
  assign upper_ok = IS64 || (addr[AW-1:AW/2] == '0);
  assign hit      = upper_ok && ((addr & ~MASK) == (BASE & ~MASK));
  assign xaddr    = ((addr & MASK) | (vec & ~MASK)) & KEEP;
endmodule

// File: rtl/obwin_prio.sv
module obwin_prio import obwin_pkg::*; #(
  parameter int NUM_WIN = 6
) (
  input  logic [MAX_WIN-1:0] hits,
  output logic [MAX_WIN-1:0] onehot,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    any    = 1'b0;
    for (int g = MAX_WIN - 1; g >= 0; g--) begin
      if (hits[g] && g < NUM_WIN) begin
        onehot = '0;
        onehot[g] = 1'b1;
        idx    = IDX_W'(g);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/obwin_xlat.sv
module obwin_xlat import obwin_pkg::*; #(
  parameter int NUM_WIN  = 6,
  parameter bit DYN_XLAT = 1'b1,
  parameter logic [MAX_WIN*AW-1:0] WIN_BASE = {
    64'h0000_0000_0000_0000, 64'h0000_0010_0000_0000, 64'h0000_0000_0000_0000,
    64'h0000_0000_FE00_0000, 64'h0000_0000_ABCD_E000, 64'h0000_0000_1234_0000},
  parameter logic [MAX_WIN*AW-1:0] WIN_HIGH = {
    64'h0000_0000_0000_0FFF, 64'h0000_0010_FFFF_FFFF, 64'h0000_0000_0000_007F,
    64'h0000_0000_FFFF_FFFF, 64'h0000_0000_ABCD_FFFF, 64'h0000_0000_1234_FFFF},
  parameter logic [MAX_WIN*AW-1:0] WIN_VEC = {
    64'h7777_0000_0000_0000, 64'hABCD_0000_0000_0000, 64'h0000_0000_8765_4380,
    64'h0000_0000_4000_0000, 64'h0000_0000_FEDC_0000, 64'h0000_0000_5671_0000},
  parameter logic [MAX_WIN-1:0] WIN_IS64 = 6'b110000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [AW-1:0]    lk_addr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_data,
  output logic             out_valid,
  output logic             out_hit,
  output logic [IDX_W-1:0] out_win,
  output logic [AW-1:0]    out_addr
);
  logic [MAX_WIN*AW-1:0] vec_q;
  logic [MAX_WIN-1:0]    hit_raw;
  logic [MAX_WIN-1:0]    sel_oh;
  logic [AW-1:0]         xa [MAX_WIN];
  logic [AW-1:0]         xa_sel;
  logic [IDX_W-1:0]      sel_idx;
  logic                  any_hit;

  obwin_vec_regs #(.NUM_WIN(NUM_WIN), .DYN_XLAT(DYN_XLAT), .VEC_INIT(WIN_VEC)) u_vec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .vec_q(vec_q)
  );

  for (genvar g = 0; g < MAX_WIN; g++) begin : g_win
    obwin_match #(
      .BASE(WIN_BASE[g*AW +: AW]), .HIGH(WIN_HIGH[g*AW +: AW]), .IS64(WIN_IS64[g])
    ) u_match (
      .addr(lk_addr), .vec(vec_q[g*AW +: AW]), .hit(hit_raw[g]), .xaddr(xa[g])
    );
  end

  obwin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .hits(hit_raw), .onehot(sel_oh), .idx(sel_idx), .any(any_hit)
  );

  // AND-OR select keyed by the one-hot winner
  always_comb begin
    xa_sel = '0;
    for (int g = 0; g < MAX_WIN; g++)
      if (sel_oh[g]) xa_sel = xa_sel | xa[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_win   <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= lk_valid;
      if (lk_valid && any_hit) begin
        out_hit  <= 1'b1;
        out_win  <= sel_idx;
        out_addr <= xa_sel;
      end else begin
        out_hit  <= 1'b0;
        out_win  <= '0;
        out_addr <= '0;
      end
    end
  end
endmodule

// File: rtl/obwin_xlat_chk.sv
module obwin_xlat_chk import obwin_pkg::*; #(
  parameter int NUM_WIN = 6,
  parameter logic [MAX_WIN*AW-1:0] WIN_BASE = '0,
  parameter logic [MAX_WIN*AW-1:0] WIN_HIGH = '0,
  parameter logic [MAX_WIN-1:0]    WIN_IS64 = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [AW-1:0]    lk_addr,
  input logic             out_valid,
  input logic             out_hit,
  input logic [IDX_W-1:0] out_win,
  input logic [AW-1:0]    out_addr
);
  function automatic logic [AW-1:0] mask_of(input logic [IDX_W-1:0] w);
    logic [AW-1:0] r;
    r = '0;
    for (int g = 0; g < MAX_WIN; g++)
      if (w == IDX_W'(g)) r = win_mask(WIN_BASE[g*AW +: AW], WIN_HIGH[g*AW +: AW], WIN_IS64[g]);
    return r;
  endfunction

  function automatic logic [AW-1:0] base_of(input logic [IDX_W-1:0] w);
    logic [AW-1:0] r;
    r = '0;
    for (int g = 0; g < MAX_WIN; g++)
      if (w == IDX_W'(g)) r = WIN_BASE[g*AW +: AW];
    return r;
  endfunction

  function automatic logic is64_of(input logic [IDX_W-1:0] w);
    logic r;
    r = 1'b0;
    for (int g = 0; g < MAX_WIN; g++)
      if (w == IDX_W'(g)) r = WIN_IS64[g];
    return r;
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!out_valid && !out_hit)); // R1
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> (($past(lk_addr) & ~mask_of(out_win)) == (base_of(out_win) & ~mask_of(out_win)))); // R2
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> (((out_addr ^ $past(lk_addr)) & mask_of(out_win)) == '0)); // R3
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    (out_hit && !is64_of(out_win)) |-> (out_addr[AW-1:AW/2] == '0)); // R4
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (out_addr == '0 && out_win == '0)); // R6
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> (int'(out_win) < NUM_WIN)); // R8
endmodule

bind obwin_xlat obwin_xlat_chk #(
  .NUM_WIN(NUM_WIN), .WIN_BASE(WIN_BASE), .WIN_HIGH(WIN_HIGH), .WIN_IS64(WIN_IS64)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .out_valid(out_valid), .out_hit(out_hit), .out_win(out_win), .out_addr(out_addr)
);

// File: tb/obwin_xlat_tb.sv
`timescale 1ns/1ps
module obwin_xlat_tb;
  import obwin_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst;
  logic             lk_valid, wr_en;
  logic [AW-1:0]    lk_addr, wr_data;
  logic [IDX_W-1:0] wr_idx;
  logic             out_valid, out_hit;
  logic [IDX_W-1:0] out_win;
  logic [AW-1:0]    out_addr;

  logic             s_valid, s_wr_en;
  logic [AW-1:0]    s_addr, s_wr_data;
  logic [IDX_W-1:0] s_wr_idx;
  logic             s_out_valid, s_out_hit;
  logic [IDX_W-1:0] s_out_win;
  logic [AW-1:0]    s_out_addr;

  obwin_xlat u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .out_valid(out_valid), .out_hit(out_hit), .out_win(out_win), .out_addr(out_addr)
  );

  obwin_xlat #(.NUM_WIN(3), .DYN_XLAT(1'b0)) u_dut_fixed (
    .clk(clk), .rst(rst), .lk_valid(s_valid), .lk_addr(s_addr),
    .wr_en(s_wr_en), .wr_idx(s_wr_idx), .wr_data(s_wr_data),
    .out_valid(s_out_valid), .out_hit(s_out_hit), .out_win(s_out_win), .out_addr(s_out_addr)
  );

  typedef struct {
    logic            hit;
    logic [IDX_W-1:0] win;
    logic [AW-1:0]   a;
    string           tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h ({hit,win,addr})", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per valid result
  always @(negedge clk) begin
    exp_t e;
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 result without lookup", {out_hit, out_win, out_addr}, '0);
      end else begin
        e = q.pop_front();
        check(out_hit == e.hit && out_win == e.win && out_addr == e.a, e.tag,
              {out_hit, out_win, out_addr}, {e.hit, e.win, e.a});
      end
    end
  end

  task automatic look(input logic [AW-1:0] a, input logic h, input logic [IDX_W-1:0] w,
                      input logic [AW-1:0] x, input string tag);
    exp_t e;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; wr_en = 1'b0;
    e.hit = h; e.win = w; e.a = x; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic look_wr(input logic [AW-1:0] a, input logic [IDX_W-1:0] w,
                         input logic [AW-1:0] x, input logic [IDX_W-1:0] wi,
                         input logic [AW-1:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    wr_en = 1'b1; wr_idx = wi; wr_data = wd;
    e.hit = 1'b1; e.win = w; e.a = x; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [IDX_W-1:0] wi, input logic [AW-1:0] wd);
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b1; wr_idx = wi; wr_data = wd;
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic s_look(input logic [AW-1:0] a, input logic h, input logic [AW-1:0] x,
                        input string tag);
    @(negedge clk);
    s_valid = 1'b1; s_addr = a; s_wr_en = 1'b0;
    @(negedge clk);
    s_valid = 1'b0;
    check(s_out_valid && s_out_hit == h && s_out_addr == x, tag,
          {s_out_hit, s_out_win, s_out_addr}, {h, s_out_win, x});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; lk_valid = 1'b0; lk_addr = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    s_valid = 1'b0; s_addr = '0; s_wr_en = 1'b0; s_wr_idx = '0; s_wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_hit && out_win == 0 && out_addr == 0, "R11 reset state",
          {out_hit, out_win, out_addr}, '0);

    // R3: translation examples, one per narrow window
    look(64'h0000_0000_1234_0ABC, 1'b1, 3'd0, 64'h0000_0000_5671_0ABC, "R3 window0 64KiB");
    look(64'h0000_0000_ABCD_F123, 1'b1, 3'd1, 64'h0000_0000_FEDC_1123, "R3 window1 8KiB");
    look(64'h0000_0000_FFFE_DCBA, 1'b1, 3'd2, 64'h0000_0000_41FE_DCBA, "R3 window2 32MiB");
    // R7: 0x71 is in window3 and window5; window3 wins, vector bits above span kept
    look(64'h0000_0000_0000_0071, 1'b1, 3'd3, 64'h0000_0000_8765_43F1, "R7 R3 overlap low index");
    // R2: edges of window0
    look(64'h0000_0000_1234_0000, 1'b1, 3'd0, 64'h0000_0000_5671_0000, "R2 base hits");
    look(64'h0000_0000_1234_FFFF, 1'b1, 3'd0, 64'h0000_0000_5671_FFFF, "R2 high hits");
    look(64'h0000_0000_1235_0000, 1'b0, 3'd0, 64'h0, "R2 above high misses R6");
    look(64'h0000_0000_1233_FFFF, 1'b0, 3'd0, 64'h0, "R2 below base misses R6");
    // R4: narrow window ignores addresses with upper bits set
    look(64'h0000_0001_1234_0ABC, 1'b0, 3'd0, 64'h0, "R4 upper bits block narrow hit");
    // R5: wide windows
    look(64'h0000_0010_1234_5678, 1'b1, 3'd4, 64'hABCD_0000_1234_5678, "R5 wide window4");
    look(64'h0000_0000_0000_0200, 1'b1, 3'd5, 64'h7777_0000_0000_0200, "R5 wide window5");
    look(64'h0000_0000_0000_0080, 1'b1, 3'd5, 64'h7777_0000_0000_0080, "R7 R2 past window3 high");
    look(64'h0000_0000_0000_1000, 1'b0, 3'd0, 64'h0, "R6 miss above window5");
    look(64'h0000_0011_0000_0000, 1'b0, 3'd0, 64'h0, "R6 miss above window4");
    idle();

    // R9: same-cycle write uses the old vector, next cycle the new one
    look_wr(64'h0000_0000_1234_0001, 3'd0, 64'h0000_0000_5671_0001, 3'd0,
            64'h0000_0000_2222_FFFF, "R9 same-cycle old vector");
    look(64'h0000_0000_1234_0002, 1'b1, 3'd0, 64'h0000_0000_2222_0002, "R9 R3 next-cycle new vector");
    // R4: upper half of a narrow window's vector has no effect
    wr(3'd1, 64'hFFFF_FFFF_1111_0000);
    look(64'h0000_0000_ABCD_E005, 1'b1, 3'd1, 64'h0000_0000_1111_0005, "R4 narrow vector upper ignored");
    // R10: out-of-range index writes change nothing
    wr(3'd6, 64'hDEAD_BEEF_DEAD_BEEF);
    wr(3'd7, 64'hDEAD_BEEF_DEAD_BEEF);
    look(64'h0000_0000_1234_0003, 1'b1, 3'd0, 64'h0000_0000_2222_0003, "R10 idx6 idx7 ignored w0");
    look(64'h0000_0000_0000_0300, 1'b1, 3'd5, 64'h7777_0000_0000_0300, "R10 idx6 idx7 ignored w5");
    idle();
    idle();

    // R11: reset restores the vectors
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_hit && out_addr == 0, "R11 outputs cleared by reset",
          {out_hit, out_win, out_addr}, '0);
    look(64'h0000_0000_1234_0ABC, 1'b1, 3'd0, 64'h0000_0000_5671_0ABC, "R11 vector0 restored");
    look(64'h0000_0000_ABCD_E005, 1'b1, 3'd1, 64'h0000_0000_FEDC_0005, "R11 vector1 restored");
    idle();
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R1 every lookup answered", 68'(q.size()), '0);

    // Fixed-vector instance with three windows
    s_look(64'h0000_0000_0000_0071, 1'b0, 64'h0, "R8 window3 disabled");
    s_look(64'h0000_0000_1234_0ABC, 1'b1, 64'h0000_0000_5671_0ABC, "R8 window0 enabled");
    @(negedge clk);
    s_wr_en = 1'b1; s_wr_idx = 3'd0; s_wr_data = 64'h0000_0000_1111_0000;
    @(negedge clk);
    s_wr_en = 1'b0;
    s_look(64'h0000_0000_1234_0ABC, 1'b1, 64'h0000_0000_5671_0ABC, "R10 fixed vectors ignore writes");

    summary();
    $finish;
  end
endmodule